// File: doc/BRIEF.md
# Local Countdown Timer with Prescaler

This block is a 32-bit countdown timer local to one processor core. Software programs a ratio code into a divide register, sets a mode, a mask and an interrupt vector in a vector-table entry, and then writes a start value into the initial-count register. That write loads the counter and restarts the prescaler. After that the counter steps down once per divided tick.

In one-shot mode the counter stops at zero. In periodic mode it returns to the start value one divided tick after it reaches zero, so each period lasts (start value + 1) ticks. The cycle in which the counter first reads zero raises a one-clock interrupt pulse carrying the entry's vector, unless the entry is masked. All four registers are visible through a combinational read port.

Top module: `lct_timer`

## Requirements
- R1: After reset the initial count, current count and divide register read 0, the vector entry reads 0x0001_0000 (masked, one-shot, vector 0), and the interrupt output is low.
- R2: Select 2 stores only bits 3, 1 and 0 of the written data. A read at select 2 returns the written value AND 0xB.
- R3: With ratio code v = {d[3], d[1:0]}, the prescale divisor is 2^((v+1) mod 8). Codes 0x0, 0x1, 0x2, 0x3, 0x8, 0x9, 0xA and 0xB give 2, 4, 8, 16, 32, 64, 128 and 1.
- R4: A write of N at select 0 loads the counter and restarts the prescaler. j clock edges after the write edge, the count reads N - floor(j/D), where D is the divisor. A later write restarts the sequence.
- R5: In one-shot mode (entry bit 17 = 0) the count stops at 0 and no further pulse occurs.
- R6: In periodic mode (bit 17 = 1) the count reads N - (floor(j/D) mod (N+1)).
- R7: The interrupt output is high for exactly the one cycle in which the count first reads 0 in each period. During that cycle the vector output equals entry bits 7:0.
- R8: With the mask bit (entry bit 16) set, no pulse occurs and the count still runs.
- R9: A rewrite of the vector entry while the counter runs leaves the count sequence unchanged. The new mode, mask and vector govern the next expiry.
- R10: An initial count of 0 keeps the count at 0 and raises no pulse.
- R11: Writes at select 1 (current count) have no effect.
- R12: The read select picks 0 initial count, 1 current count, 2 divide register, 3 vector entry. Unused entry bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data, combinational |
| irq_pulse | output | 1 | One-cycle expiry interrupt |
| irq_vector | output | 8 | Vector of the timer entry |

## Verification
A write is taken at the clock edge where wr_en is high. The loaded count is readable in the cycle after that edge, and j edges later the count reflects floor(j/D) divided ticks. The interrupt pulse is registered on the same edge that brings the count to zero, so it is visible in that cycle. An entry rewrite applies from the edge that takes the write. The bench drives inputs and samples outputs on the falling edge, keeps its own edge counter j from the load edge, and compares the count and the pulse every cycle against values computed from j, D, N and the modelled mode.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int VEC_W        = 8;
  localparam int DIV_W        = 4;
  localparam int LVT_MASK_BIT = 16;
  localparam int LVT_PER_BIT  = 17;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_CUR  = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_LVT  = 2'd3
  } lct_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } lct_entry_t;
endpackage

// File: rtl/lct_prescale.sv
module lct_prescale
  import lct_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  localparam int SH_W = $clog2(PRE_W + 1);

  logic [SH_W-1:0]  shift;
  logic [PRE_W-1:0] mask;
  logic [PRE_W-1:0] pre_q, pre_d;

  // ratio code skips bit 2; shift wraps modulo 8
  always_comb begin
    shift = SH_W'({div_code[3], div_code[1:0]}) + SH_W'(1);
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(shift));
    end
  end

  always_comb begin
    if (clr) pre_d = '0;
    else     pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = ((pre_q & mask) == mask);

  // R3: with the ratio held, a divided tick is never followed by another at once
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0) |=> (!tick || shift != $past(shift) || $past(clr)));
endmodule

// File: rtl/lct_regs.sv
module lct_regs
  import lct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_sel,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic             load,
  output logic [CNT_W-1:0] init_q,
  output logic [DIV_W-1:0] div_q,
  output lct_entry_t       entry_q,
  output logic [31:0]      rd_data
);
  logic       div_we, ent_we;
  lct_entry_t entry_d;

  assign load   = wr_en && (lct_sel_e'(wr_sel) == SEL_INIT);
  assign div_we = wr_en && (lct_sel_e'(wr_sel) == SEL_DIV);
  assign ent_we = wr_en && (lct_sel_e'(wr_sel) == SEL_LVT);

  always_comb begin
    entry_d.periodic = wr_data[LVT_PER_BIT];
    entry_d.masked   = wr_data[LVT_MASK_BIT];
    entry_d.vector   = wr_data[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    init_q <= '0;
    else if (load) init_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_we) div_q <= wr_data[DIV_W-1:0] & DIV_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q.periodic <= 1'b0;
      entry_q.masked   <= 1'b1;
      entry_q.vector   <= '0;
    end else if (ent_we) begin
      entry_q <= entry_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (lct_sel_e'(rd_sel))
      SEL_INIT: rd_data[CNT_W-1:0] = init_q;
      SEL_CUR:  rd_data[CNT_W-1:0] = cur_cnt;
      SEL_DIV:  rd_data[DIV_W-1:0] = div_q;
      default: begin
        rd_data[VEC_W-1:0]   = entry_q.vector;
        rd_data[LVT_MASK_BIT] = entry_q.masked;
        rd_data[LVT_PER_BIT]  = entry_q.periodic;
      end
    endcase
  end

  // R2: the divide register takes only the kept bits of a write
  assert_div_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> (div_q == ($past(wr_data[DIV_W-1:0]) & DIV_KEEP)));
endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic             masked,
  output logic [CNT_W-1:0] cur_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             irq_d;

  assign cnt_en = load | tick;

  always_comb begin
    cnt_d = cur_q;
    irq_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (cur_q != '0) begin
        cnt_d = cur_q - CNT_W'(1);
        irq_d = (cur_q == CNT_W'(1)) && !masked;
      end else if (periodic) begin
        cnt_d = reload_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cnt_en) cur_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R5: an expired one-shot count stays at zero
  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && !periodic && !load) |=> (cur_q == '0));
  // R7: a pulse only accompanies a zero count
  assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cur_q == '0));
  // R4: a running count moves down by at most one per edge
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cur_q != '0) |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) - CNT_W'(1)));
endmodule

// File: rtl/lct_timer.sv
module lct_timer
  import lct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  logic             rst_s0, rst_s1;
  logic             rst_sn;
  logic             load;
  logic             tick;
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cur_cnt;
  logic [DIV_W-1:0] div_q;
  lct_entry_t       entry_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_sn = rst_s1;

  lct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .cur_cnt (cur_cnt),
    .load    (load),
    .init_q  (init_q),
    .div_q   (div_q),
    .entry_q (entry_q),
    .rd_data (rd_data)
  );

  lct_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sn),
    .clr      (load),
    .div_code (div_q),
    .tick     (tick)
  );

  lct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sn),
    .load       (load),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (init_q),
    .tick       (tick),
    .periodic   (entry_q.periodic),
    .masked     (entry_q.masked),
    .cur_q      (cur_cnt),
    .irq_q      (irq_pulse)
  );

  assign irq_vector = entry_q.vector;

  // R8: a pulse never follows a cycle in which the entry was masked
  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_pulse |-> !$past(entry_q.masked));
endmodule

// File: tb/lct_timer_test.sv
module lct_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;

  int m_n, m_d, m_per, m_mask, m_vec, j;

  always #4 clk = ~clk;

  lct_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  function automatic int div_of(int code);
    int v;
    v = ((code >> 1) & 4) | (code & 3);
    return 1 << ((v + 1) % 8);
  endfunction

  function automatic int exp_cnt(int n, int d, int per, int jj);
    int t;
    if (n == 0) return 0;
    t = jj / d;
    if (per != 0) return n - (t % (n + 1));
    return (t >= n) ? 0 : n - t;
  endfunction

  function automatic int exp_irq(int n, int d, int per, int msk, int jj);
    if (n == 0 || msk != 0) return 0;
    if (jj < n * d) return 0;
    if (per == 0) return (jj == n * d) ? 1 : 0;
    return (((jj - n * d) % ((n + 1) * d)) == 0) ? 1 : 0;
  endfunction

  function automatic logic [31:0] entry_word(int per, int msk, int vec);
    return (32'(per & 1) << 17) | (32'(msk & 1) << 16) | 32'(vec & 8'hFF);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (j=%0d)", tag, act, exp, j);
    end
  endtask

  task automatic check_now(string tag);
    chk({tag, " count"}, rd_data, 32'(exp_cnt(m_n, m_d, m_per, j)));
    chk({tag, " pulse R7"}, 32'(irq_pulse), 32'(exp_irq(m_n, m_d, m_per, m_mask, j)));
    if (irq_pulse) chk({tag, " vector R7"}, 32'(irq_vector), 32'(m_vec));
  endtask

  task automatic cfg_write(logic [1:0] s, logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int n, string tag);
    rd_sel = 2'd1;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'(n);
    @(negedge clk);
    wr_en = 1'b0;
    m_n = n; j = 0;
    check_now(tag);
  endtask

  task automatic step(string tag);
    @(negedge clk);
    j++;
    check_now(tag);
  endtask

  task automatic wr_step(logic [1:0] s, logic [31:0] d, string tag);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    j++;
    check_now(tag);
  endtask

  task automatic setup(int code, int per, int msk, int vec);
    cfg_write(2'd2, 32'(code));
    cfg_write(2'd3, entry_word(per, msk, vec));
    m_d = div_of(code); m_per = per; m_mask = msk; m_vec = vec;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R12 read selects
    chk("R1 init", rd_data, 32'h0);
    rd_sel = 2'd1; #1 chk("R1 current", rd_data, 32'h0);
    rd_sel = 2'd2; #1 chk("R1 divide", rd_data, 32'h0);
    rd_sel = 2'd3; #1 chk("R1 R12 entry", rd_data, 32'h0001_0000);
    chk("R1 pulse", 32'(irq_pulse), 32'h0);
    @(negedge clk);

    // R2 kept bits, R12 entry layout
    cfg_write(2'd2, 32'hFFFF_FFFF);
    rd_sel = 2'd2; #1 chk("R2 divide keep", rd_data, 32'hB);
    cfg_write(2'd3, 32'hFFFF_FFFF);
    rd_sel = 2'd3; #1 chk("R12 entry unused bits", rd_data, 32'h0003_00FF);
    @(negedge clk);

    // R3 divide-by-1 code, R5 one-shot saturation
    setup(4'hB, 0, 0, 8'h21);
    load(6, "R3 R5 div1");
    for (int k = 0; k < 20; k++) step("R3 R5 div1");

    // R3 largest divisor, R6 periodic
    setup(4'hA, 1, 0, 8'h33);
    load(2, "R3 R6 div128");
    for (int k = 0; k < 800; k++) step("R3 R6 div128");

    // R4 restart by a second load
    setup(4'h0, 0, 0, 8'h10);
    load(10, "R4 first");
    for (int k = 0; k < 7; k++) step("R4 first");
    load(3, "R4 restart");
    rd_sel = 2'd0; #1 chk("R4 R12 init readback", rd_data, 32'd3);
    rd_sel = 2'd1; #1;
    for (int k = 0; k < 14; k++) step("R4 restart");

    // R8 masked: count runs, no pulse
    setup(4'hB, 1, 1, 8'h44);
    load(4, "R8 masked");
    for (int k = 0; k < 25; k++) step("R8 masked");

    // R9 entry rewrite during count
    setup(4'hB, 0, 0, 8'h40);
    load(5, "R9");
    step("R9");
    wr_step(2'd3, entry_word(1, 0, 8'h77), "R9");
    m_per = 1; m_vec = 8'h77;
    for (int k = 0; k < 27; k++) step("R9 periodic");

    // R10 zero initial count
    setup(4'hB, 1, 0, 8'h55);
    load(0, "R10");
    for (int k = 0; k < 20; k++) step("R10");

    // R11 current-count writes ignored
    setup(4'h1, 0, 0, 8'h66);
    load(8, "R11");
    for (int k = 0; k < 3; k++) step("R11");
    wr_step(2'd1, 32'h0000_FFFF, "R11");
    for (int k = 0; k < 36; k++) step("R11");

    // random trials, R3 R4 R5 R6 R7 R8
    for (int t = 0; t < 25; t++) begin
      int code, per, msk, vec, n, len;
      code = int'($urandom_range(0, 15));
      per  = int'($urandom_range(0, 1));
      msk  = ($urandom_range(0, 3) == 0) ? 1 : 0;
      vec  = int'($urandom_range(0, 255));
      n    = int'($urandom_range(1, 12));
      setup(code, per, msk, vec);
      rd_sel = 2'd2; #1 chk("R2 random divide", rd_data, 32'(code & 4'hB));
      load(n, "random");
      len = n * m_d + 2 * (n + 1) * m_d + 4;
      if (len > 1500) len = 1500;
      for (int k = 0; k < len; k++) step("random");
    end

    summary();
    $finish;
  end
endmodule